// File: doc/BRIEF.md
# Guard-Bit Arithmetic Unit for a Fixed-Point DSP Datapath

This block is the single-precision arithmetic stage of a fixed-point signal-processing core. Each enabled cycle it takes two two's-complement operands, an operation code and a saturation-mode bit. The operation code selects one of ten arithmetic functions. The result register and three status flags are updated on the next rising clock edge.

Every function goes through one adder that is one bit wider than the data, so that bit acts as a guard bit. A front stage shapes the adder inputs for each operation. It can invert an operand, replace an operand with a constant (zero, plus one or minus one) and select the carry input. A back stage reads the guard bit to detect signed overflow. It then either clamps the value to the nearest representable extreme or reports the unsigned carry. It also chooses the value to write and derives the flags. Comparison changes only the flags. Average, maximum and minimum reuse the same guard-extended sum.

Top module: `dsp_alu`

## Requirements
- R1: While `rst_n` is low, `res`, `flag_c`, `flag_n` and `flag_z` are all 0.
- R2: Opcode values are 0 ADD, 1 SUB, 2 ABS, 3 CMP, 4 NEG, 5 INC, 6 DEC, 7 AVG, 8 MAX, 9 MIN. When `en` is high at a rising edge, the outputs show that operation from that edge on.
- R3: ADD with `sat_mode`=0 gives (A+B) mod 2^W and sets `flag_c` to the unsigned carry out. With `sat_mode`=1 it gives the signed sum clamped to [-2^(W-1), 2^(W-1)-1] and sets `flag_c` when clamping occurred.
- R4: SUB with `sat_mode`=0 gives (A-B) mod 2^W and sets `flag_c` to 1 exactly when A >= B as unsigned numbers (no borrow). With `sat_mode`=1 it gives the clamped signed difference and sets `flag_c` when clamping occurred.
- R5: ABS gives the clamped |A| and NEG gives the clamped -A. For both, the most negative input yields 2^(W-1)-1, and `flag_c` marks clamping.
- R6: INC gives the clamped A+1 and DEC gives the clamped A-1, with `flag_c` marking clamping.
- R7: AVG gives floor((A+B)/2) of the signed operands and clears `flag_c`.
- R8: CMP leaves `res` unchanged. It sets the flags as SUB with `sat_mode`=1 would.
- R9: MAX writes the signed larger of A and B and MIN writes the signed smaller. Both clear `flag_c`.
- R10: After any flag-updating operation, `flag_n` equals the most significant bit of the value produced and `flag_z` is 1 exactly when that value is zero.
- R11: With `en` low, or with an opcode of 10 to 15, neither `res` nor any flag changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Execute the presented operation this cycle |
| op | input | 4 | Operation code |
| sat_mode | input | 1 | ADD/SUB: 1 clamps, 0 wraps and reports carry |
| a | input | W | Operand A, two's complement |
| b | input | W | Operand B, two's complement |
| res | output | W | Result register |
| flag_c | output | 1 | Carry (wrapping ADD/SUB) or clamping indicator |
| flag_n | output | 1 | Sign of the produced value |
| flag_z | output | 1 | Produced value is zero |

## Verification
The bench builds the unit with W=6. At that width every pair of operands can be applied to every operation and to both saturation modes, in about fifty thousand operations. The full sweep therefore covers every overflow boundary, the most negative operand for ABS and NEG, the odd negative sums that decide the rounding direction of AVG, and equal operands for MAX and MIN. Directed steps then confirm that CMP, the unused opcodes and a deasserted enable leave the registered state unchanged.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_ABS = 4'd2,
    OP_CMP = 4'd3,
    OP_NEG = 4'd4,
    OP_INC = 4'd5,
    OP_DEC = 4'd6,
    OP_AVG = 4'd7,
    OP_MAX = 4'd8,
    OP_MIN = 4'd9
  } alu_op_e;

  localparam int unsigned OP_W = 4;
endpackage

// File: rtl/alu_pre.sv
module alu_pre
  import alu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  output logic [W-1:0]    opa,
  output logic [W-1:0]    opb,
  output logic            cin
);
  localparam logic [W-1:0] K_ZERO = '0;
  localparam logic [W-1:0] K_ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] K_MONE = '1;

  logic a_neg;
  assign a_neg = a[W-1];

  always_comb begin
    opa = a;
    opb = b;
    cin = 1'b0;
    case (op)
      OP_ADD, OP_AVG: begin
        opb = b;
        cin = 1'b0;
      end
      OP_SUB, OP_CMP, OP_MAX, OP_MIN: begin
        opb = ~b;
        cin = 1'b1;
      end
      OP_ABS: begin
        opa = a ^ {W{a_neg}};
        opb = K_ZERO;
        cin = a_neg;
      end
      OP_NEG: begin
        opa = K_ZERO;
        opb = ~a;
        cin = 1'b1;
      end
      OP_INC: opb = K_ONE;
      OP_DEC: opb = K_MONE;
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int unsigned W        = 16,
  parameter bit          LSB_CARRY = 1'b1
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         cin,
  output logic [W:0]   sum
);
  generate
    if (LSB_CARRY) begin : g_lsb
      logic [W+1:0] wide;
      logic         sum_lsb_unused;
      assign wide = {opa[W-1], opa, 1'b1} + {opb[W-1], opb, cin};
      assign {sum, sum_lsb_unused} = wide;
    end else begin : g_direct
      assign sum = {opa[W-1], opa} + {opb[W-1], opb} + {{W{1'b0}}, cin};
    end
  endgenerate
endmodule

// File: rtl/alu_post.sv
module alu_post
  import alu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [OP_W-1:0] op,
  input  logic            sat_mode,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic            opa_msb,
  input  logic            opb_msb,
  input  logic [W:0]      sum,
  output logic [W-1:0]    value,
  output logic            c_out,
  output logic            n_out,
  output logic            z_out,
  output logic            wr_res,
  output logic            wr_flags
);
  localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};

  logic         ovf;
  logic         carry;
  logic [W-1:0] clamped;

  assign ovf     = sum[W] ^ sum[W-1];
  assign carry   = sum[W] ^ opa_msb ^ opb_msb;
  assign clamped = ovf ? (sum[W] ? S_MIN : S_MAX) : sum[W-1:0];

  always_comb begin
    value    = clamped;
    c_out    = ovf;
    wr_res   = 1'b1;
    wr_flags = 1'b1;
    case (op)
      OP_ADD, OP_SUB: begin
        value = sat_mode ? clamped : sum[W-1:0];
        c_out = sat_mode ? ovf : carry;
      end
      OP_ABS, OP_NEG, OP_INC, OP_DEC: ;
      OP_CMP: wr_res = 1'b0;
      OP_AVG: begin
        value = sum[W:1];
        c_out = 1'b0;
      end
      OP_MAX: begin
        value = sum[W] ? b : a;
        c_out = 1'b0;
      end
      OP_MIN: begin
        value = sum[W] ? a : b;
        c_out = 1'b0;
      end
      default: begin
        wr_res   = 1'b0;
        wr_flags = 1'b0;
      end
    endcase
  end

  assign n_out = value[W-1];
  assign z_out = (value == '0);
endmodule

// File: rtl/dsp_alu.sv
module dsp_alu
  import alu_pkg::*;
#(
  parameter int unsigned W         = 16,
  parameter bit          LSB_CARRY = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [3:0]   op,
  input  logic         sat_mode,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         flag_c,
  output logic         flag_n,
  output logic         flag_z
);
  logic [W-1:0] opa, opb, value;
  logic         cin, c_v, n_v, z_v, wr_res, wr_flags;
  logic [W:0]   sum;

  logic [W-1:0] res_d;
  logic         c_d, n_d, z_d;

  alu_pre #(.W(W)) u_pre (
    .op(op), .a(a), .b(b), .opa(opa), .opb(opb), .cin(cin)
  );

  alu_adder #(.W(W), .LSB_CARRY(LSB_CARRY)) u_add (
    .opa(opa), .opb(opb), .cin(cin), .sum(sum)
  );

  alu_post #(.W(W)) u_post (
    .op(op), .sat_mode(sat_mode), .a(a), .b(b),
    .opa_msb(opa[W-1]), .opb_msb(opb[W-1]), .sum(sum),
    .value(value), .c_out(c_v), .n_out(n_v), .z_out(z_v),
    .wr_res(wr_res), .wr_flags(wr_flags)
  );

  always_comb begin
    res_d = res;
    c_d   = flag_c;
    n_d   = flag_n;
    z_d   = flag_z;
    if (en && wr_res) res_d = value;
    if (en && wr_flags) begin
      c_d = c_v;
      n_d = n_v;
      z_d = z_v;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res    <= '0;
      flag_c <= 1'b0;
      flag_n <= 1'b0;
      flag_z <= 1'b0;
    end else begin
      res    <= res_d;
      flag_c <= c_d;
      flag_n <= n_d;
      flag_z <= z_d;
    end
  end
endmodule

// File: rtl/alu_chk.sv
module alu_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic [3:0]   op,
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [W-1:0] res,
  input logic         flag_c,
  input logic         flag_n,
  input logic         flag_z
);
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!en || op > 4'd9) |=> ($stable(res) && $stable(flag_c) && $stable(flag_n) && $stable(flag_z)));

  p_cmp_keeps_res_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == 4'd3) |=> $stable(res));

  p_abs_nonneg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == 4'd2) |=> !res[W-1]);

  p_avg_no_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == 4'd7) |=> !flag_c);

  p_max_pick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == 4'd8) |=> ((res == $past(a) || res == $past(b)) &&
                            $signed(res) >= $signed($past(a)) &&
                            $signed(res) >= $signed($past(b))));

  p_min_pick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == 4'd9) |=> ((res == $past(a) || res == $past(b)) &&
                            $signed(res) <= $signed($past(a)) &&
                            $signed(res) <= $signed($past(b))));

  p_flags_track_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op <= 4'd9 && op != 4'd3) |=> (flag_z == (res == '0) && flag_n == res[W-1]));
endmodule

bind dsp_alu alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .op(op), .a(a), .b(b),
  .res(res), .flag_c(flag_c), .flag_n(flag_n), .flag_z(flag_z)
);

// File: tb/dsp_alu_tb.sv
module dsp_alu_tb;
  localparam int W    = 6;
  localparam int MOD  = 2 ** W;
  localparam int SMAX = 2 ** (W - 1) - 1;
  localparam int SMIN = -(2 ** (W - 1));

  logic         clk = 1'b0;
  logic         rst_n, en, sat_mode;
  logic [3:0]   op;
  logic [W-1:0] a, b;
  logic [W-1:0] res;
  logic         flag_c, flag_n, flag_z;

  int tests = 0;
  int fails = 0;
  int e_res = 0, e_c = 0, e_n = 0, e_z = 0;

  always #5 clk = ~clk;

  dsp_alu #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .op(op), .sat_mode(sat_mode),
    .a(a), .b(b), .res(res), .flag_c(flag_c), .flag_n(flag_n), .flag_z(flag_z)
  );

  function automatic int sx(input int u);
    return (u >= MOD / 2) ? u - MOD : u;
  endfunction

  task automatic put(input int v, input int c, input bit wr);
    int u;
    u = v & (MOD - 1);
    if (wr) e_res = u;
    e_c = c;
    e_n = (u >> (W - 1)) & 1;
    e_z = (u == 0) ? 1 : 0;
  endtask

  task automatic put_sat(input int v, input bit wr);
    if (v > SMAX) put(SMAX, 1, wr);
    else if (v < SMIN) put(SMIN, 1, wr);
    else put(v, 0, wr);
  endtask

  task automatic model(input int opc, input bit sm, input int ua, input int ub);
    int sa, sb, t;
    sa = sx(ua);
    sb = sx(ub);
    case (opc)
      0: if (sm) put_sat(sa + sb, 1); else put(ua + ub, (ua + ub >= MOD) ? 1 : 0, 1);
      1: if (sm) put_sat(sa - sb, 1); else put(ua - ub, (ua >= ub) ? 1 : 0, 1);
      2: put_sat(sa < 0 ? -sa : sa, 1);
      3: put_sat(sa - sb, 0);
      4: put_sat(-sa, 1);
      5: put_sat(sa + 1, 1);
      6: put_sat(sa - 1, 1);
      7: begin t = sa + sb; put(t >>> 1, 0, 1); end
      8: put(sa > sb ? sa : sb, 0, 1);
      9: put(sa < sb ? sa : sb, 0, 1);
      default: ;
    endcase
  endtask

  function automatic string tag(input int opc);
    case (opc)
      0: return "R3";  1: return "R4";  2: return "R5";  3: return "R8";
      4: return "R5";  5: return "R6";  6: return "R6";  7: return "R7";
      8: return "R9";  9: return "R9";  default: return "R11";
    endcase
  endfunction

  task automatic compare(input string req);
    tests++;
    if (res !== e_res[W-1:0] || flag_c !== e_c[0] || flag_n !== e_n[0] || flag_z !== e_z[0]) begin
      fails++;
      $display("FAIL %s op=%0d a=%0d b=%0d sat=%0d: res=%0d c=%0d n=%0d z=%0d expected res=%0d c=%0d n=%0d z=%0d",
               req, op, a, b, sat_mode, res, flag_c, flag_n, flag_z, e_res, e_c, e_n, e_z);
    end
  endtask

  task automatic run(input int opc, input bit sm, input int ua, input int ub, input bit go);
    @(negedge clk);
    en = go; op = opc[3:0]; sat_mode = sm; a = ua[W-1:0]; b = ub[W-1:0];
    if (go) model(opc, sm, ua, ub);
    @(negedge clk);
    if (go) compare(tag(opc)); else compare("R11");
    en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; op = '0; sat_mode = 1'b0; a = '0; b = '0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;

    // R2 R3 R4 R5 R6 R7 R8 R9 R10: exhaustive sweep at W=6
    for (int o = 0; o < 10; o++) begin
      for (int m = 0; m < ((o < 2) ? 2 : 1); m++) begin
        for (int x = 0; x < MOD; x++) begin
          for (int y = 0; y < MOD; y++) begin
            run(o, m[0], x, y, 1'b1);
          end
        end
      end
    end

    // R11: unused opcodes and deasserted enable leave state alone
    run(0, 1'b0, 5, 9, 1'b1);
    for (int o = 10; o < 16; o++) run(o, 1'b1, o, 63 - o, 1'b1);
    run(0, 1'b0, 20, 30, 1'b0);
    run(7, 1'b1, 63, 1, 1'b0);

    // R8: CMP after a known result changes only flags
    run(0, 1'b0, 11, 3, 1'b1);
    run(3, 1'b0, 7, 7, 1'b1);
    run(3, 1'b0, 32, 31, 1'b1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule